// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns eight external interrupt pins into interrupt requests. A 2-bit sense field for each pin picks one of four triggers: low level, any change, falling edge or rising edge. The two halves of the pin vector use different detection methods. Pins 7 to 4 are synchronised and sampled on the system clock, and an edge is an inequality between two successive samples. Pins 3 to 0 capture their edges in flops clocked by the pin itself, so a glitch shorter than a clock period is still recorded. That capture then crosses into the clock domain through a synchroniser.

An edge event sets a sticky per-pin flag. Software clears a flag by writing a one to its bit. Level mode does not use the flag: the request follows the synchronised pin directly and falls as soon as the pin returns high. Each pin's request passes through a mask bit and then through a global interrupt-enable input. The gated requests appear as a vector and as one OR-reduced interrupt line. A small register bus holds the sense fields, the mask and the flags.

Top module: `extint_sense`

## Requirements
- R1: Sense fields reset to 0. Address 0 holds pins 3..0 and address 1 holds pins 7..4. Pin n occupies bits [2(n mod 4)+1 : 2(n mod 4)] of its register. Codes: 00 = low level, 01 = any change, 10 = falling edge, 11 = rising edge. Written values read back unchanged.
- R2: On pins 7..4, a matching edge sets the pin's flag on the third rising clock edge after the pin changes, and not earlier. A pulse held for longer than one clock period always sets the flag.
- R3: In any-change mode, both a falling and a rising transition set the flag.
- R4: Pins 3..0 capture their edges without the clock, so a pulse narrower than one clock period still sets the flag. The flag is set on the third rising clock edge after the pin edge.
- R5: In level mode the request is asserted from the second rising clock edge after the pin goes low. It stays asserted while the pin is low and deasserts on the second rising edge after the pin goes high. Level mode never sets a flag.
- R6: Flags read at address 3, bit n for pin n. A flag stays set until a write to address 3 with a one in its bit, which clears it at that write's clock edge. Zero bits in that write leave flags unchanged.
- R7: reqVec[n] is asserted only while mask bit n and gie are both 1. Flags set whatever the mask and gie are, and a pending flag appears on reqVec as soon as its mask bit is set. irq is the OR of reqVec.
- R8: The mask register sits at address 2, bit n for pin n. It resets to 0 and reads back what was written.
- R9: On pins 7..4, switching a pin from falling to rising mode while the pin is high sets its flag one clock after the write. With the mask set, this raises an interrupt. If the mask is cleared first and the flag is cleared before the mask is restored, no request appears.
- R10: An edge opposite to the selected one leaves the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 8 | External interrupt pins |
| gie | input | 1 | Global interrupt enable |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address (0/1 sense, 2 mask, 3 flags) |
| busWdata | input | 8 | Register write data |
| busRdata | output | 8 | Register read data (combinational) |
| reqVec | output | 8 | Gated per-pin interrupt requests |
| irq | output | 1 | OR of all gated requests |

## Verification
Latencies are counted from the moment the pin changes. An edge flag is due on the third rising clock edge: two synchroniser flops plus the flag register on the sampled bank, and two synchroniser flops plus the flag register on the toggle-capture bank. A level request is due on the second rising edge, and a mode-change side effect shows one edge after the write. Inputs change and outputs are sampled 5 ns after a rising edge. Each edge test checks both one edge early, when the flag must still be clear, and at the due edge, so an extra or missing pipeline stage is caught. Gating by mask and enable is combinational, so those checks are made 1 ns after the input changes.

// File: rtl/extint_pkg.sv
`timescale 1ns/1ps
package extint_pkg;
  localparam int PIN_CNT = 8;
  localparam int REG_W   = 8;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  // strobes from control to datapath
  typedef struct packed {
    logic               clrWr;
    logic [PIN_CNT-1:0] clrBits;
  } dpStrobe_t;
endpackage

// File: rtl/extint_sampled_det.sv
`timescale 1ns/1ps
module extint_sampled_det
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   pinIn,
  input  sense_e mode,
  output logic   evt,
  output logic   pinLow
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic cur;
  logic trans;
  logic prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
  end

  assign cur    = syncQ[SYNC_STAGES-1];
  assign pinLow = ~cur;
  // polarity-adjusted sample: a falling edge becomes a rising one
  assign trans  = (mode == SENSE_FALL) ? ~cur : cur;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b1;
    else       prevQ <= trans;
  end

  always_comb begin
    unique case (mode)
      SENSE_LOW: evt = 1'b0;
      SENSE_ANY: evt = trans ^ prevQ;
      default:   evt = trans & ~prevQ;
    endcase
  end
endmodule

// File: rtl/extint_async_catch.sv
`timescale 1ns/1ps
module extint_async_catch
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   pinIn,
  input  sense_e mode,
  output logic   evt,
  output logic   pinLow
);
  logic riseTog;
  logic fallTog;
  logic [SYNC_STAGES-1:0] riseS;
  logic [SYNC_STAGES-1:0] fallS;
  logic [SYNC_STAGES-1:0] lvlS;
  logic riseD;
  logic fallD;
  logic riseHit;
  logic fallHit;

  // edge capture clocked by the pin itself
  always_ff @(posedge pinIn or negedge rstN) begin
    if (!rstN) riseTog <= 1'b0;
    else       riseTog <= ~riseTog;
  end

  always_ff @(negedge pinIn or negedge rstN) begin
    if (!rstN) fallTog <= 1'b0;
    else       fallTog <= ~fallTog;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseS <= '0;
      fallS <= '0;
      lvlS  <= '1;
      riseD <= 1'b0;
      fallD <= 1'b0;
    end else begin
      riseS <= {riseS[SYNC_STAGES-2:0], riseTog};
      fallS <= {fallS[SYNC_STAGES-2:0], fallTog};
      lvlS  <= {lvlS[SYNC_STAGES-2:0], pinIn};
      riseD <= riseS[SYNC_STAGES-1];
      fallD <= fallS[SYNC_STAGES-1];
    end
  end

  assign riseHit = riseS[SYNC_STAGES-1] ^ riseD;
  assign fallHit = fallS[SYNC_STAGES-1] ^ fallD;
  assign pinLow  = ~lvlS[SYNC_STAGES-1];

  always_comb begin
    unique case (mode)
      SENSE_LOW:  evt = 1'b0;
      SENSE_ANY:  evt = riseHit | fallHit;
      SENSE_FALL: evt = fallHit;
      default:    evt = riseHit;
    endcase
  end
endmodule

// File: rtl/extint_ctrl.sv
`timescale 1ns/1ps
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int PINS = PIN_CNT,
  parameter int DW   = REG_W,
  parameter int AW   = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            busWr,
  input  logic [AW-1:0]   busAddr,
  input  logic [DW-1:0]   busWdata,
  input  logic [PINS-1:0] flagsIn,
  output logic [DW-1:0]   busRdata,
  output logic [2*PINS-1:0] modeVec,
  output logic [PINS-1:0] maskVec,
  output dpStrobe_t       strobe
);
  localparam int SENSE_REGS = (2 * PINS) / DW;
  localparam int MASK_ADDR  = SENSE_REGS;
  localparam int FLAG_ADDR  = SENSE_REGS + 1;

  logic [2*PINS-1:0] modeQ;
  logic [PINS-1:0]   maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
      maskQ <= '0;
    end else if (busWr) begin
      for (int k = 0; k < SENSE_REGS; k++) begin
        if (busAddr == AW'(k)) modeQ[k*DW +: DW] <= busWdata;
      end
      if (busAddr == AW'(MASK_ADDR)) maskQ <= busWdata[PINS-1:0];
    end
  end

  assign modeVec = modeQ;
  assign maskVec = maskQ;

  always_comb begin
    strobe.clrWr   = busWr && (busAddr == AW'(FLAG_ADDR));
    strobe.clrBits = busWdata[PINS-1:0];
  end

  always_comb begin
    busRdata = '0;
    for (int k = 0; k < SENSE_REGS; k++) begin
      if (busAddr == AW'(k)) busRdata = modeQ[k*DW +: DW];
    end
    if (busAddr == AW'(MASK_ADDR)) busRdata = DW'(maskQ);
    if (busAddr == AW'(FLAG_ADDR)) busRdata = DW'(flagsIn);
  end
endmodule

// File: rtl/extint_datapath.sv
`timescale 1ns/1ps
module extint_datapath
  import extint_pkg::*;
#(
  parameter int PINS        = PIN_CNT,
  parameter int ASYNC_PINS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PINS-1:0]   pinIn,
  input  logic [2*PINS-1:0] modeVec,
  input  logic [PINS-1:0]   maskVec,
  input  logic              gie,
  input  dpStrobe_t         strobe,
  output logic [PINS-1:0]   flagsQ,
  output logic [PINS-1:0]   reqVec
);
  logic [PINS-1:0] evtVec;
  logic [PINS-1:0] lowVec;
  logic [PINS-1:0] clrMask;

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    sense_e modeP;
    assign modeP = sense_e'(modeVec[2*p +: 2]);

    if (p < ASYNC_PINS) begin : g_async
      extint_async_catch #(.SYNC_STAGES(SYNC_STAGES)) u_catch (
        .clk    (clk),
        .rstN   (rstN),
        .pinIn  (pinIn[p]),
        .mode   (modeP),
        .evt    (evtVec[p]),
        .pinLow (lowVec[p])
      );
    end else begin : g_samp
      extint_sampled_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
        .clk    (clk),
        .rstN   (rstN),
        .pinIn  (pinIn[p]),
        .mode   (modeP),
        .evt    (evtVec[p]),
        .pinLow (lowVec[p])
      );
    end

    assign reqVec[p] = gie & maskVec[p] &
                       ((modeP == SENSE_LOW) ? lowVec[p] : flagsQ[p]);
  end

  assign clrMask = strobe.clrWr ? strobe.clrBits : '0;

  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagsQ <= '0;
    else       flagsQ <= evtVec | (flagsQ & ~clrMask);
  end
endmodule

// File: rtl/extint_sense.sv
`timescale 1ns/1ps
module extint_sense
  import extint_pkg::*;
#(
  parameter int PINS        = PIN_CNT,
  parameter int ASYNC_PINS  = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DW          = REG_W,
  parameter int AW          = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PINS-1:0] pinIn,
  input  logic            gie,
  input  logic            busWr,
  input  logic [AW-1:0]   busAddr,
  input  logic [DW-1:0]   busWdata,
  output logic [DW-1:0]   busRdata,
  output logic [PINS-1:0] reqVec,
  output logic            irq
);
  logic [2*PINS-1:0] modeVec;
  logic [PINS-1:0]   maskVec;
  logic [PINS-1:0]   flagsQ;
  dpStrobe_t         strobe;

  extint_ctrl #(.PINS(PINS), .DW(DW), .AW(AW)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .flagsIn  (flagsQ),
    .busRdata (busRdata),
    .modeVec  (modeVec),
    .maskVec  (maskVec),
    .strobe   (strobe)
  );

  extint_datapath #(
    .PINS(PINS), .ASYNC_PINS(ASYNC_PINS), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .modeVec (modeVec),
    .maskVec (maskVec),
    .gie     (gie),
    .strobe  (strobe),
    .flagsQ  (flagsQ),
    .reqVec  (reqVec)
  );

  assign irq = |reqVec;
endmodule

// File: rtl/extint_sense_chk.sv
`timescale 1ns/1ps
module extint_sense_chk #(
  parameter int PINS = 8,
  parameter int DW   = 8,
  parameter int AW   = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              gie,
  input logic              busWr,
  input logic [AW-1:0]     busAddr,
  input logic [DW-1:0]     busWdata,
  input logic [2*PINS-1:0] modeVec,
  input logic [PINS-1:0]   maskVec,
  input logic [PINS-1:0]   flagsQ,
  input logic [PINS-1:0]   reqVec
);
  localparam logic [AW-1:0] FLAG_ADDR = AW'((2 * PINS) / DW + 1);

  logic [PINS-1:0] levelPins;
  always_comb begin
    for (int p = 0; p < PINS; p++) levelPins[p] = (modeVec[2*p +: 2] == 2'b00);
  end

  // R7: no request without the global enable
  a_r7_gie_gates: assert property (@(posedge clk) disable iff (!rstN)
    !gie |-> (reqVec == '0));

  // R7: no request on a masked pin
  a_r7_mask_gates: assert property (@(posedge clk) disable iff (!rstN)
    ((reqVec & ~maskVec) == '0));

  // R6: flags only fall after a clear write
  a_r6_flags_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !($past(busWr) && ($past(busAddr) == FLAG_ADDR)) |->
      (($past(flagsQ) & ~flagsQ) == '0));

  // R6: a clear write only clears the bits it names
  a_r6_clear_named_only: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busWr) && ($past(busAddr) == FLAG_ADDR)) |->
      (($past(flagsQ) & ~flagsQ & ~$past(busWdata[PINS-1:0])) == '0));

  // R5: level mode never raises a flag
  a_r5_level_no_flag: assert property (@(posedge clk) disable iff (!rstN)
    ((flagsQ & ~$past(flagsQ) & $past(levelPins)) == '0));
endmodule

bind extint_sense extint_sense_chk #(.PINS(PINS), .DW(DW), .AW(AW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .gie      (gie),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .modeVec  (modeVec),
  .maskVec  (maskVec),
  .flagsQ   (flagsQ),
  .reqVec   (reqVec)
);

// File: tb/sim_extint_sense.sv
`timescale 1ns/1ps
module sim_extint_sense;
  logic       clk;
  logic       rstN;
  logic [7:0] pinIn;
  logic       gie;
  logic       busWr;
  logic [1:0] busAddr;
  logic [7:0] busWdata;
  logic [7:0] busRdata;
  logic [7:0] reqVec;
  logic       irq;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  extint_sense u0 (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .gie(gie),
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .reqVec(reqVec), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    busAddr  = a;
    busWdata = d;
    busWr    = 1'b1;
    tick(1);
    busWr    = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic tReset();
    logic [7:0] d;
    chk(reqVec, 8'h00, "R7 reset reqVec");
    chk({7'b0, irq}, 8'h00, "R7 reset irq");
    readReg(2'd0, d); chk(d, 8'h00, "R1 reset sense low");
    readReg(2'd1, d); chk(d, 8'h00, "R1 reset sense high");
    readReg(2'd2, d); chk(d, 8'h00, "R8 reset mask");
    readReg(2'd3, d); chk(d, 8'h00, "R6 reset flags");
  endtask

  task automatic tRegMap();
    logic [7:0] d;
    writeReg(2'd1, 8'h1B);
    readReg(2'd1, d); chk(d, 8'h1B, "R1 sense high readback");
    writeReg(2'd0, 8'hE4);
    readReg(2'd0, d); chk(d, 8'hE4, "R1 sense low readback");
    writeReg(2'd2, 8'hA5);
    readReg(2'd2, d); chk(d, 8'hA5, "R8 mask readback");
    writeReg(2'd0, 8'h00);
    writeReg(2'd1, 8'h00);
    writeReg(2'd2, 8'h00);
  endtask

  task automatic tSampledRise();
    logic [7:0] d;
    writeReg(2'd1, 8'h03);       // pin4 rising
    writeReg(2'd2, 8'h10);
    pinIn[4] = 1'b0;
    tick(3);
    readReg(2'd3, d); chk(d, 8'h00, "R10 falling edge in rising mode");
    chk({7'b0, irq}, 8'h00, "R10 no irq");
    pinIn[4] = 1'b1;
    tick(2);
    readReg(2'd3, d); chk(d, 8'h00, "R2 flag not before third edge");
    tick(1);
    readReg(2'd3, d); chk(d, 8'h10, "R2 flag on third edge");
    chk(reqVec, 8'h10, "R2 reqVec");
    chk({7'b0, irq}, 8'h01, "R7 irq from flag");
    tick(4);
    readReg(2'd3, d); chk(d, 8'h10, "R6 flag sticky");
    writeReg(2'd3, 8'h00);
    readReg(2'd3, d); chk(d, 8'h10, "R6 zero write no effect");
    writeReg(2'd3, 8'h10);
    readReg(2'd3, d); chk(d, 8'h00, "R6 write one clears");
    chk({7'b0, irq}, 8'h00, "R6 irq drops after clear");
  endtask

  task automatic tSampledPulse();
    logic [7:0] d;
    writeReg(2'd1, 8'h08);       // pin5 falling
    writeReg(2'd2, 8'h20);
    pinIn[5] = 1'b0;
    #25;
    pinIn[5] = 1'b1;
    tick(3);
    readReg(2'd3, d); chk(d, 8'h20, "R2 pulse over one period caught");
    chk(reqVec, 8'h20, "R2 pulse reqVec");
    writeReg(2'd3, 8'h20);
  endtask

  task automatic tAnyChange();
    logic [7:0] d;
    writeReg(2'd1, 8'h40);       // pin7 any change
    writeReg(2'd2, 8'h80);
    pinIn[7] = 1'b0;
    tick(3);
    readReg(2'd3, d); chk(d, 8'h80, "R3 falling transition");
    writeReg(2'd3, 8'h80);
    readReg(2'd3, d); chk(d, 8'h00, "R3 cleared");
    pinIn[7] = 1'b1;
    tick(2);
    readReg(2'd3, d); chk(d, 8'h00, "R3 rising not yet");
    tick(1);
    readReg(2'd3, d); chk(d, 8'h80, "R3 rising transition");
    writeReg(2'd3, 8'h80);
    writeReg(2'd1, 8'h00);
  endtask

  task automatic tAsyncNarrow();
    logic [7:0] d;
    writeReg(2'd0, 8'h0B);       // pin1 falling, pin0 rising
    writeReg(2'd2, 8'h03);
    pinIn[1:0] = 2'b00;
    #4;
    pinIn[1:0] = 2'b11;
    tick(2);
    readReg(2'd3, d); chk(d, 8'h00, "R4 flag not before third edge");
    tick(1);
    readReg(2'd3, d); chk(d, 8'h03, "R4 narrow pulse caught");
    chk(reqVec, 8'h03, "R4 reqVec");
    writeReg(2'd3, 8'h03);
    readReg(2'd3, d); chk(d, 8'h00, "R4 cleared");
  endtask

  task automatic tLevel();
    logic [7:0] d;
    writeReg(2'd2, 8'h04);       // pin2 stays in level mode
    pinIn[2] = 1'b0;
    tick(1);
    chk(reqVec, 8'h00, "R5 level not before second edge");
    tick(1);
    chk(reqVec, 8'h04, "R5 level request");
    tick(5);
    chk(reqVec, 8'h04, "R5 level held");
    readReg(2'd3, d); chk(d, 8'h00, "R5 no flag in level mode");
    pinIn[2] = 1'b1;
    tick(1);
    chk(reqVec, 8'h04, "R5 still low in synchroniser");
    tick(1);
    chk(reqVec, 8'h00, "R5 level released");
    pinIn[2] = 1'b0;
    tick(2);
    gie = 1'b0;
    #1;
    chk(reqVec, 8'h00, "R7 gie gates");
    gie = 1'b1;
    #1;
    chk(reqVec, 8'h04, "R7 gie restored");
    writeReg(2'd2, 8'h00);
    chk(reqVec, 8'h00, "R7 mask gates level");
    pinIn[2] = 1'b1;
    tick(3);
  endtask

  task automatic tMaskedFlag();
    logic [7:0] d;
    writeReg(2'd1, 8'h03);       // pin4 rising, mask clear
    pinIn[4] = 1'b0;
    tick(3);
    pinIn[4] = 1'b1;
    tick(3);
    readReg(2'd3, d); chk(d, 8'h10, "R7 flag set while masked");
    chk(reqVec, 8'h00, "R7 masked reqVec");
    chk({7'b0, irq}, 8'h00, "R7 masked irq");
    writeReg(2'd2, 8'h10);
    chk(reqVec, 8'h10, "R7 pending flag after unmask");
    writeReg(2'd3, 8'h10);
    writeReg(2'd2, 8'h00);
  endtask

  task automatic tModeChange();
    logic [7:0] d;
    writeReg(2'd1, 8'h20);       // pin6 falling, pin held high
    writeReg(2'd2, 8'h40);
    tick(3);
    readReg(2'd3, d); chk(d, 8'h00, "R9 no flag before change");
    writeReg(2'd1, 8'h30);       // to rising while enabled
    tick(1);
    readReg(2'd3, d); chk(d, 8'h40, "R9 spurious flag");
    chk({7'b0, irq}, 8'h01, "R9 spurious irq");
    writeReg(2'd3, 8'h40);
    writeReg(2'd1, 8'h20);
    tick(2);
    readReg(2'd3, d); chk(d, 8'h00, "R9 back to falling quiet");
    writeReg(2'd2, 8'h00);       // safe sequence
    writeReg(2'd1, 8'h30);
    tick(1);
    chk({7'b0, irq}, 8'h00, "R9 masked change no irq");
    readReg(2'd3, d); chk(d, 8'h40, "R9 flag still raised internally");
    writeReg(2'd3, 8'h40);
    writeReg(2'd2, 8'h40);
    tick(2);
    chk(reqVec, 8'h00, "R9 safe sequence reqVec");
    chk({7'b0, irq}, 8'h00, "R9 safe sequence irq");
  endtask

  initial begin
    rstN = 1'b0; pinIn = 8'hFF; gie = 1'b0;
    busWr = 1'b0; busAddr = 2'd0; busWdata = 8'h00;
    repeat (3) @(posedge clk);
    #5;
    rstN = 1'b1;
    tick(1);
    tReset();
    tRegMap();
    gie = 1'b1;
    tSampledRise();
    tSampledPulse();
    tAnyChange();
    tAsyncNarrow();
    tLevel();
    tMaskedFlag();
    tModeChange();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule